// File: doc/BRIEF.md
# Buffered Dual-Channel Complementary PWM Generator

The block contains an 8-bit up-counter that advances on each cycle where `tick` is high. It runs from zero up to a programmable period limit, then starts again at zero. The counter drives two PWM channels, A and B. Each channel has a true output and an inverted companion output. A 2-bit mode code for each channel picks one of four behaviours: outputs off, a complementary pair, a true output that is high first, or a true output that is low first. The point inside the period where each channel switches is a compare value.

Compare values written by the host go into a holding register first. They reach the channel only at the wrap point, so a period never has a pulse of odd length. The wrap raises a sticky overflow flag, and a clear strobe removes it. The host drives a plain register write port with three address bits and eight data bits. This port has no back-pressure: every strobe is accepted in the cycle it is presented. The mode, period and enable registers take effect on the next cycle.

Address map: 0 is the period limit. 1 and 2 are the held compare values for A and B. 3 and 4 are the mode codes for A and B, in data bits [1:0]. 5 is the run enable, in data bit 0.

Top module: `pwm_pair_gen`

## Requirements
- R1: After reset, all four PWM outputs and `ovf_flag` are low, the counter and both compare registers (live and held) are zero, and the period limit is 0xFF. A channel started with no further writes therefore has a period of 256 ticks.
- R2: While enabled, the counter changes only on cycles where `tick` is high. On such a cycle it steps by one, or it returns to zero when its value is equal to or above the period limit.
- R3: A write to address 1 or 2 only loads the held value. The live compare value copies the held value on the ticked cycle in which the counter wraps, and never at any other time.
- R4: `ovf_flag` goes high on the cycle after a wrap and stays high until `flag_clr` is pulsed. If a clear and a new wrap arrive in the same cycle, the flag stays set.
- R5: Mode code 00 drives both outputs of the channel low, and this holds with or without ticks.
- R6: Mode code 01 on a ticked count works as follows. The true output falls when the count equals the compare value and rises when the count equals 1. The inverted output rises when the count equals the compare value and falls when the count equals 0.
- R7: Mode code 10 works the same as code 01 for the true output. The inverted output stays low.
- R8: Mode code 11 drives the true output high when the count equals the compare value and low when the count equals 1. The inverted output stays low.
- R9: In mode 01, the true output falls and the inverted output rises in the same cycle, with no gap between them.
- R10: While the enable bit is 0, all outputs are low and the counter is held at zero.
- R11: If a compare value is above the period limit, no match ever occurs. The true output then stays at the level set at count 0 or 1.
- R12: When a compare match and the count-0 or count-1 action fall on the same count, the match action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Count enable pulse |
| flag_clr | input | 1 | Write-one-to-clear for the overflow flag |
| pwm_a | output | 1 | Channel A true output |
| pwm_a_n | output | 1 | Channel A inverted output |
| pwm_b | output | 1 | Channel B true output |
| pwm_b_n | output | 1 | Channel B inverted output |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong count shows up within one period. It moves the edges of both channels and shifts when `ovf_flag` rises, so a per-cycle comparison against an arithmetic model detects it after at most limit+1 ticks. A compare value that commits at the wrong time shows up as an edge at the old or new position in the period where the write happened. A wrong output level left over in a channel shows up on the next ticked cycle, or at once after a mode or enable change.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    PM_OFF        = 2'b00,
    PM_COMP       = 2'b01,
    PM_HIGH_FIRST = 2'b10,
    PM_LOW_FIRST  = 2'b11
  } pwm_mode_e;

  localparam logic [AW-1:0] ADDR_TOP  = 3'd0;
  localparam int            ADDR_CMP0 = 1;
  localparam int            ADDR_MOD0 = 3;
  localparam logic [AW-1:0] ADDR_CTRL = 3'd5;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [W-1:0]              wr_data,
  input  logic                      commit,
  output logic [W-1:0]              top_q,
  output logic                      en_q,
  output logic [NCH-1:0][1:0]       mode_q,
  output logic [NCH-1:0][W-1:0]     live_q
);
  logic [NCH-1:0][W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '1;
      en_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_TOP)  top_q <= wr_data;
      if (wr_addr == ADDR_CTRL) en_q  <= wr_data[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CMP_ADDR = AW'(ADDR_CMP0 + i);
    localparam logic [AW-1:0] MOD_ADDR = AW'(ADDR_MOD0 + i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[i] <= '0;
        live_q[i] <= '0;
        mode_q[i] <= PM_OFF;
      end else begin
        if (wr_en && wr_addr == CMP_ADDR) hold_q[i] <= wr_data;
        if (wr_en && wr_addr == MOD_ADDR) mode_q[i] <= wr_data[1:0];
        if (commit) live_q[i] <= hold_q[i];
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] top,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic         wrap,
  output logic         flag_q
);
  assign wrap = en && tick && (cnt_q >= top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!en)       cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      flag_q <= wrap | (flag_q & ~flag_clr);
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         lvl_q,
  output logic         lvl_n_q
);
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic match, at_one, at_zero;
  logic lvl_d, lvl_n_d;

  assign match   = (cnt == cmp);
  assign at_one  = (cnt == CNT_ONE);
  assign at_zero = (cnt == '0);

  always_comb begin
    lvl_d   = lvl_q;
    lvl_n_d = lvl_n_q;
    if (!en || mode == PM_OFF) begin
      lvl_d   = 1'b0;
      lvl_n_d = 1'b0;
    end else begin
      if (tick) begin
        case (mode)
          PM_COMP, PM_HIGH_FIRST: begin
            if (match)       lvl_d = 1'b0;
            else if (at_one) lvl_d = 1'b1;
            if (match)        lvl_n_d = 1'b1;
            else if (at_zero) lvl_n_d = 1'b0;
          end
          PM_LOW_FIRST: begin
            if (match)       lvl_d = 1'b1;
            else if (at_one) lvl_d = 1'b0;
          end
          default: ;
        endcase
      end
      if (mode != PM_COMP) lvl_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      lvl_n_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      lvl_n_q <= lvl_n_d;
    end
  end
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          tick,
  input  logic          flag_clr,
  output logic          pwm_a,
  output logic          pwm_a_n,
  output logic          pwm_b,
  output logic          pwm_b_n,
  output logic          ovf_flag
);
  localparam int NCH = 2;

  logic [W-1:0]          top_q;
  logic                  en_q;
  logic [NCH-1:0][1:0]   mode_q;
  logic [NCH-1:0][W-1:0] live_q;
  logic [W-1:0]          cnt_q;
  logic                  wrap;
  logic [NCH-1:0]        lvl, lvl_n;

  pwm_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(wrap), .top_q(top_q), .en_q(en_q),
    .mode_q(mode_q), .live_q(live_q)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .top(top_q),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .wrap(wrap), .flag_q(ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pwm_channel #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick),
      .mode(mode_q[i]), .cnt(cnt_q), .cmp(live_q[i]),
      .lvl_q(lvl[i]), .lvl_n_q(lvl_n[i])
    );
  end

  assign pwm_a   = lvl[0];
  assign pwm_a_n = lvl_n[0];
  assign pwm_b   = lvl[1];
  assign pwm_b_n = lvl_n[1];
endmodule

// File: rtl/pwm_pair_gen_chk.sv
module pwm_pair_gen_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                flag_clr,
  input logic                en_q,
  input logic [W-1:0]        top_q,
  input logic [W-1:0]        cnt_q,
  input logic                wrap,
  input logic [1:0][1:0]     mode_q,
  input logic [1:0][W-1:0]   live_q,
  input logic                pwm_a,
  input logic                pwm_a_n,
  input logic                pwm_b,
  input logic                pwm_b_n,
  input logic                ovf_flag
);
  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && flag_clr && !wrap |=> !ovf_flag);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick && (cnt_q < top_q) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !tick |=> $stable(cnt_q));
  // R10
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !(pwm_a || pwm_a_n || pwm_b || pwm_b_n) && cnt_q == '0);
  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] == 2'b00 |=> !pwm_a && !pwm_a_n);
  // R7
  single_ended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0][1] || mode_q[1][1] |=> (!pwm_a_n || !mode_q[0][1]) && (!pwm_b_n || !mode_q[1][1]));
  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(live_q));
  // R9
  pair_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick && mode_q[0] == 2'b01 && cnt_q == live_q[0] |=> !pwm_a && pwm_a_n);
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .flag_clr(flag_clr),
  .en_q(en_q), .top_q(top_q), .cnt_q(cnt_q), .wrap(wrap),
  .mode_q(mode_q), .live_q(live_q), .pwm_a(pwm_a), .pwm_a_n(pwm_a_n),
  .pwm_b(pwm_b), .pwm_b_n(pwm_b_n), .ovf_flag(ovf_flag)
);

// File: tb/pwm_pair_gen_test.sv
`timescale 1ns/1ps
module pwm_pair_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b1;
  logic       flag_clr = 1'b0;
  logic       pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;
  logic  prev_a = 1'b0;

  always #4 clk = ~clk;

  pwm_pair_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .flag_clr(flag_clr),
    .pwm_a(pwm_a), .pwm_a_n(pwm_a_n), .pwm_b(pwm_b), .pwm_b_n(pwm_b_n),
    .ovf_flag(ovf_flag)
  );

  // Reference model built from the requirements
  logic [7:0] m_cnt, m_top;
  logic [7:0] m_hold [2];
  logic [7:0] m_live [2];
  logic [1:0] m_mode [2];
  logic       m_en, m_flag;
  logic       m_lv [2];
  logic       m_inv [2];
  logic       m_wrap;

  assign m_wrap = m_en && tick && (m_cnt >= m_top);

  function automatic logic true_next(logic [1:0] md, logic [7:0] c, logic [7:0] cp,
                                     logic cur, logic tk, logic on);
    if (!on || md == 2'd0) return 1'b0;
    if (!tk) return cur;
    if (c == cp) return (md == 2'd3);
    if (c == 8'd1) return (md != 2'd3);
    return cur;
  endfunction

  function automatic logic inv_next(logic [1:0] md, logic [7:0] c, logic [7:0] cp,
                                    logic cur, logic tk, logic on);
    if (!on || md != 2'd1) return 1'b0;
    if (!tk) return cur;
    if (c == cp) return 1'b1;
    if (c == 8'd0) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_top <= 8'hFF; m_en <= 0; m_flag <= 0;
      for (int i = 0; i < 2; i++) begin
        m_hold[i] <= 0; m_live[i] <= 0; m_mode[i] <= 0; m_lv[i] <= 0; m_inv[i] <= 0;
      end
    end else begin
      m_flag <= m_wrap | (m_flag & ~flag_clr);
      if (!m_en) m_cnt <= 0;
      else if (tick) m_cnt <= m_wrap ? 8'd0 : m_cnt + 8'd1;
      for (int i = 0; i < 2; i++) begin
        m_lv[i]  <= true_next(m_mode[i], m_cnt, m_live[i], m_lv[i], tick, m_en);
        m_inv[i] <= inv_next(m_mode[i], m_cnt, m_live[i], m_inv[i], tick, m_en);
        if (m_wrap) m_live[i] <= m_hold[i];
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_top <= wr_data;
          3'd1: m_hold[0] <= wr_data;
          3'd2: m_hold[1] <= wr_data;
          3'd3: m_mode[0] <= wr_data[1:0];
          3'd4: m_mode[1] <= wr_data[1:0];
          3'd5: m_en <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock; compare all outputs against the model at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check(cur_tag, {pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag},
          {m_lv[0], m_inv[0], m_lv[1], m_inv[1], m_flag});
    if (m_en && m_mode[0] == 2'd1 && prev_a && !pwm_a)
      check("R9", {4'b0, pwm_a_n}, 5'b00001);
    prev_a = pwm_a;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic setup(logic [7:0] t, logic [1:0] ma, logic [7:0] ca,
                       logic [1:0] mb, logic [7:0] cb);
    wr(3'd5, 8'd0);
    wr(3'd0, t);
    wr(3'd1, ca);
    wr(3'd2, cb);
    wr(3'd3, {6'd0, ma});
    wr(3'd4, {6'd0, mb});
    wr(3'd5, 8'd1);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cycles_to_flag;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_tag = "R1";
    @(negedge clk);
    check("R1", {pwm_a, pwm_a_n, pwm_b, pwm_b_n, ovf_flag}, 5'b0);
    run(4);
    // R1: default limit 0xFF gives a 256-tick period
    wr(3'd3, 8'd2);
    wr(3'd5, 8'd1);
    cycles_to_flag = 0; seen = 0;
    for (int k = 1; k <= 300; k++) begin
      cyc();
      if (!seen && ovf_flag) begin seen = 1; cycles_to_flag = k; end
    end
    check("R1", {cycles_to_flag == 256, 4'b0}, 5'b10000);

    // sweep of limit, compare value and mode
    foreach (m_cnt[b]) ; // no-op keeps loop style uniform
    for (int ti = 0; ti < 3; ti++) begin
      for (int md = 1; md <= 3; md++) begin
        automatic int t = (ti == 0) ? 2 : (ti == 1) ? 3 : 5;
        for (int c = 0; c <= t + 2; c++) begin
          if (c > t)       cur_tag = "R11";
          else if (c <= 1) cur_tag = "R12";
          else if (md == 1) cur_tag = "R6";
          else if (md == 2) cur_tag = "R7";
          else              cur_tag = "R8";
          setup(8'(t), 2'(md), 8'(c), 2'((md % 3) + 1), 8'(t - c + 1));
          run(3 * (t + 1) + 2);
          flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
          run(t + 2);
        end
      end
    end

    // R2: sparse ticks
    cur_tag = "R2";
    setup(8'd4, 2'd1, 8'd2, 2'd3, 8'd3);
    for (int k = 0; k < 60; k++) begin
      tick = (k % 3 == 0);
      cyc();
    end
    tick = 1'b1;

    // R3: compare written mid-period commits only at the wrap
    cur_tag = "R3";
    setup(8'd7, 2'd2, 8'd3, 2'd1, 8'd5);
    run(20);
    wr(3'd1, 8'd5);
    wr(3'd2, 8'd2);
    run(30);

    // R5: mode 00, including a switch to 00 while the output is high
    cur_tag = "R5";
    setup(8'd6, 2'd0, 8'd3, 2'd2, 8'd4);
    run(15);
    wr(3'd4, 8'd0);
    tick = 1'b0; run(3); tick = 1'b1;
    run(10);

    // R4: clear alone, and clear colliding with a new wrap
    cur_tag = "R4";
    setup(8'd3, 2'd1, 8'd2, 2'd3, 8'd1);
    run(6);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    for (int k = 0; k < 20; k++) begin
      flag_clr = m_wrap;
      cyc();
      flag_clr = 1'b0;
    end
    check("R4", {4'b0, ovf_flag}, 5'b00001);

    // R10: disable while running
    cur_tag = "R10";
    setup(8'd5, 2'd1, 8'd3, 2'd2, 8'd4);
    run(8);
    wr(3'd5, 8'd0);
    run(10);
    wr(3'd5, 8'd1);
    run(14);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule